// File: doc/BRIEF.md
# Power Supply Supervisor Fault Sequencer

This block is the digital timing core of a PC power supply supervisor. It watches three kinds of clean, already-digitised signals: a supply-undervoltage flag, an active-low request to turn the supply on, and a set of over-current comparator flags, one per monitored rail. It drives one output, `ps_off`. Low means the supply is enabled. High means the supply is off, either because it was not requested or because an over-current fault is active.

The request is debounced symmetrically, so a level must be stable for the debounce time before it counts. After each turn-on, over-current flags are ignored for a long blanking window. This lets the rails settle. After that window, any single channel can raise a fault. A fault is recognised only after the condition persists for the assert filter time. It is dropped only after the condition has been absent for the release filter time, which is twice the assert time. Faults are not latched, so the output goes low again by itself.

All time constants are given in microseconds and are turned into cycle counts from the clock frequency parameter. A variant parameter picks one of two assert/release filter pairs. Another parameter removes the request input for a reduced variant that runs as soon as lockout ends. Every control pin is a plain level; there is no data stream.

Top module: `pss_fault_seq`

## Requirements
- R1: `ps_off` is 0 while reset is applied and right after reset. Asserting `uv_lock` clears the whole sequencer: `ps_off` is 0 within four clock cycles, even while a fault is active.
- R2: A high level on `pwr_req_n` (1 = off request) drives `ps_off` to 1 once it has been held for the debounce time. Before that, the output keeps its previous value.
- R3: A change of `pwr_req_n` that lasts less than the debounce time has no effect on `ps_off`.
- R4: A low level on `pwr_req_n` held for the debounce time drives `ps_off` to 0. Each turn-on restarts the blanking window from zero, even if a fault was present before turn-off.
- R5: During the blanking window after a debounced turn-on, `oc_trip` has no effect on `ps_off`. An over-current present throughout the window raises `ps_off` one assert time after the window ends.
- R6: An over-current level must persist for the selected assert time before `ps_off` goes to 1. Shorter pulses are ignored. With `VARIANT`=1 the second filter pair (`ASSERT1_US`/`RELEASE1_US`) is used.
- R7: A recognised fault is dropped, and `ps_off` returns to 0 with no other stimulus, once all over-current flags have been 0 for the selected release time. A shorter gap does not drop the fault.
- R8: Each bit of `oc_trip` alone is enough to raise the fault.
- R9: When `uv_lock` ends, the sequencer restarts blanking from zero. With the request held on, a persistent over-current stays masked for the full blanking window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at `CLK_HZ` |
| rst_n | input | 1 | Asynchronous active-low reset |
| uv_lock | input | 1 | Undervoltage lockout flag, 1 = supply too low, clears the sequencer |
| pwr_req_n | input | 1 | Power-on request, 0 = on, 1 = off |
| oc_trip | input | NCH | Over-current comparator flags, 1 = over limit |
| ps_off | output | 1 | Active-low supply enable: 0 = enabled, 1 = off or fault |

## Verification
A debounce counter that is wrong or stuck shows up as `ps_off` switching early, switching late, or not switching at all. This is visible within one debounce time of a request edge. A blanking timer that does not restart shows up at the next turn-on or lockout exit as an over-current fault that appears too soon. An assert or release filter holding a wrong count, or using the wrong variant pair, moves the rising or falling edge of `ps_off` by whole filter windows. Short pulses and short gaps placed just inside the thresholds show this within one release time.

// File: rtl/pss_pkg.sv
package pss_pkg;
  // microseconds to clock cycles, never below one cycle
  function automatic int us_to_cyc(longint clk_hz, longint us);
    longint c;
    c = (clk_hz * us) / 64'd1000000;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

  // counter width able to hold the value n
  function automatic int cnt_w(int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/pss_sync.sv
module pss_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/pss_filter.sv
// Level filter: the output follows the input only after the input has
// differed from it for SET_CYC cycles (rising) or CLR_CYC cycles (falling).
module pss_filter
  import pss_pkg::*;
#(
  parameter int   SET_CYC = 4,
  parameter int   CLR_CYC = 8,
  parameter logic INIT    = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic din,
  output logic dout
);
  localparam int CW = cnt_w(imax(SET_CYC, CLR_CYC));
  localparam logic [CW-1:0] SET_LAST = CW'(SET_CYC - 1);
  localparam logic [CW-1:0] CLR_LAST = CW'(CLR_CYC - 1);

  logic [CW-1:0] run_cnt;
  logic [CW-1:0] limit;

  assign limit = dout ? CLR_LAST : SET_LAST;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout    <= INIT;
      run_cnt <= '0;
    end else if (clr) begin
      dout    <= INIT;
      run_cnt <= '0;
    end else if (din != dout) begin
      if (run_cnt == limit) begin
        dout    <= din;
        run_cnt <= '0;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end else begin
      run_cnt <= '0;
    end
  end

  // R6 (also R3 for the request path): no rise while the input is low
  p_no_early_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !dout && !din) |=> !dout);

  // R7 (also R3): no fall while the input is high
  p_no_early_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && dout && din) |=> dout);

  // R9: a clear always returns the filter to its initial level
  p_clear_to_init_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (dout == INIT));
endmodule

// File: rtl/pss_blank.sv
// Blanking timer: done rises CYC cycles after run goes high, cleared by !run.
module pss_blank
  import pss_pkg::*;
#(
  parameter int CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CW = cnt_w(CYC);
  localparam logic [CW-1:0] LAST = CW'(CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (!run)      cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LAST);

  // R5: stopping the timer always restarts the window
  p_blank_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !done);

  // R5: once expired, the window stays expired while running
  p_blank_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && done) |=> done);
endmodule

// File: rtl/pss_fault_seq.sv
module pss_fault_seq
  import pss_pkg::*;
#(
  parameter int CLK_HZ      = 25_000_000,
  parameter int NCH         = 4,
  parameter bit USE_REQ     = 1'b1,
  parameter bit VARIANT     = 1'b0,
  parameter int DEBOUNCE_US = 38_000,
  parameter int BLANK_US    = 75_000,
  parameter int ASSERT0_US  = 80,
  parameter int RELEASE0_US = 160,
  parameter int ASSERT1_US  = 150,
  parameter int RELEASE1_US = 300
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           uv_lock,
  input  logic           pwr_req_n,
  input  logic [NCH-1:0] oc_trip,
  output logic           ps_off
);
  localparam int DEB_CYC   = us_to_cyc(CLK_HZ, DEBOUNCE_US);
  localparam int BLANK_CYC = us_to_cyc(CLK_HZ, BLANK_US);
  localparam int AS_CYC    = us_to_cyc(CLK_HZ, VARIANT ? ASSERT1_US : ASSERT0_US);
  localparam int REL_CYC   = us_to_cyc(CLK_HZ, VARIANT ? RELEASE1_US : RELEASE0_US);

  logic [NCH+1:0] raw_in;
  logic [NCH+1:0] syn_in;
  logic           uv_s;
  logic           req_s;
  logic [NCH-1:0] oc_s;
  logic           req_off;
  logic           blank_done;
  logic           oc_filt;
  logic           oc_any;

  assign raw_in = {uv_lock, pwr_req_n, oc_trip};

  pss_sync #(.W(NCH + 2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw_in),
    .q    (syn_in)
  );

  assign uv_s  = syn_in[NCH+1];
  assign req_s = syn_in[NCH];
  assign oc_s  = syn_in[NCH-1:0];
  assign oc_any = |oc_s;

  generate
    if (USE_REQ) begin : g_req
      pss_filter #(.SET_CYC(DEB_CYC), .CLR_CYC(DEB_CYC), .INIT(1'b0)) u_deb (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (uv_s),
        .din  (req_s),
        .dout (req_off)
      );
    end else begin : g_noreq
      assign req_off = 1'b0;
    end
  endgenerate

  pss_blank #(.CYC(BLANK_CYC)) u_blank (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (!uv_s && !req_off),
    .done (blank_done)
  );

  pss_filter #(.SET_CYC(AS_CYC), .CLR_CYC(REL_CYC), .INIT(1'b0)) u_ocf (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (uv_s || req_off || !blank_done),
    .din  (oc_any),
    .dout (oc_filt)
  );

  assign ps_off = req_off | (oc_filt & blank_done);

  // R1: lockout forces the supply-enabled (low) state on the next cycle
  p_lockout_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    uv_s |=> !ps_off);

  // R5: no filtered fault may exist inside the blanking window
  p_mask_in_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_done |-> !oc_filt);
endmodule

// File: tb/pss_fault_seq_tb.sv
module pss_fault_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int DEB = 40;
  localparam int BLK = 60;
  localparam int AS  = 12;   // variant 1 assert
  localparam int REL = 24;   // variant 1 release

  logic clk = 1'b0;
  logic rst_n;
  logic uv_lock;
  logic pwr_req_n;
  logic [NCH-1:0] oc_trip;
  logic ps_off;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pss_fault_seq #(
    .CLK_HZ(1_000_000), .NCH(NCH), .USE_REQ(1'b1), .VARIANT(1'b1),
    .DEBOUNCE_US(DEB), .BLANK_US(BLK),
    .ASSERT0_US(8), .RELEASE0_US(16), .ASSERT1_US(AS), .RELEASE1_US(REL)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .uv_lock(uv_lock),
    .pwr_req_n(pwr_req_n), .oc_trip(oc_trip), .ps_off(ps_off)
  );

  // expected fault level while a pulse of len cycles is still applied
  function automatic logic fault_expected(int len);
    return (len >= AS + 3) ? 1'b1 : 1'b0;
  endfunction

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string tag, logic exp);
    n_chk++;
    if (ps_off !== exp) begin
      n_bad++;
      $display("FAIL %s: ps_off=%0b expected %0b at %0t", tag, ps_off, exp, $time);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; uv_lock = 1'b0; pwr_req_n = 1'b1; oc_trip = '0;
    repeat (3) @(negedge clk);
    check("R1 in reset", 1'b0);
    rst_n = 1'b1;
    step(1);
    check("R1 after reset", 1'b0);

    // R2: off request held since reset
    step(DEB - 1);
    check("R2 before debounce", 1'b0);
    step(3);
    check("R2 after debounce", 1'b1);

    // R3: short on pulse ignored
    pwr_req_n = 1'b0;
    step(DEB - 4);
    pwr_req_n = 1'b1;
    step(DEB + 6);
    check("R3 short request", 1'b1);

    // R4: turn on, then R5 blanking with over-current held
    pwr_req_n = 1'b0;
    step(DEB);
    check("R4 before debounce", 1'b1);
    step(3);
    check("R4 turned on", 1'b0);
    oc_trip[1] = 1'b1;
    step(BLK - 4);
    check("R5 masked in blank", 1'b0);
    step(AS + 6);
    check("R5 fault after blank", 1'b1);
    oc_trip = '0;
    step(REL);
    check("R7 before release", 1'b1);
    step(3);
    check("R7 self release", 1'b0);

    // R6: pulse just under the selected assert time (longer than variant 0)
    oc_trip[0] = 1'b1;
    step(AS - 3);
    oc_trip = '0;
    step(AS + 8);
    check("R6 short pulse", 1'b0);
    oc_trip[3] = 1'b1;
    step(AS);
    check("R6 before assert", 1'b0);
    step(3);
    check("R6 after assert", 1'b1);
    oc_trip = '0;
    step(REL + 3);
    check("R7 release", 1'b0);

    // R8: every channel alone
    for (int ch = 0; ch < NCH; ch++) begin
      oc_trip[ch] = 1'b1;
      step(AS + 3);
      check($sformatf("R8 channel %0d", ch), 1'b1);
      oc_trip = '0;
      step(REL + 3);
      check($sformatf("R8 channel %0d clear", ch), 1'b0);
    end

    // R7: short gap keeps fault
    oc_trip[0] = 1'b1;
    step(AS + 3);
    oc_trip = '0;
    step(REL - 4);
    oc_trip[0] = 1'b1;
    step(2);
    check("R7 short gap", 1'b1);
    oc_trip = '0;
    step(REL + 3);
    check("R7 after gap", 1'b0);

    // random pulses
    void'($urandom(32'h5eed_1234));
    for (int t = 0; t < 40; t++) begin
      int ch;
      int len;
      ch = int'($urandom % NCH);
      if ($urandom % 2 == 0) len = 1 + int'($urandom % (AS - 3));
      else                   len = AS + 3 + int'($urandom % 20);
      oc_trip[ch] = 1'b1;
      step(len);
      check($sformatf("R6 random len %0d", len), fault_expected(len));
      oc_trip = '0;
      step(REL + 3);
      check("R7 random release", 1'b0);
    end

    // R1 / R9: lockout during a fault, then blanking restarts
    oc_trip[2] = 1'b1;
    step(AS + 3);
    check("R9 fault before lockout", 1'b1);
    uv_lock = 1'b1;
    step(4);
    check("R1 lockout clears", 1'b0);
    uv_lock = 1'b0;
    step(BLK - 4);
    check("R9 masked after lockout", 1'b0);
    step(AS + 8);
    check("R9 fault after new blank", 1'b1);

    // R2 during fault, R4 blanking restarts at next turn-on
    pwr_req_n = 1'b1;
    step(DEB + 3);
    check("R2 off during fault", 1'b1);
    pwr_req_n = 1'b0;
    step(DEB + 3);
    check("R4 on again", 1'b0);
    step(BLK - 4);
    check("R4 blank restarted", 1'b0);
    oc_trip = '0;
    step(5);

    summary();
    $finish;
  end
endmodule